// File: doc/BRIEF.md
# Sharpening Filter Coefficient Normalizer

This block converts a fixed seven-tap sharpening kernel into seven normalized coefficients in a compact floating-point form. Three candidate kernels are parameters of the block. A window-size code picks one of them when a run starts. The block first adds up the taps of the chosen kernel. It then expresses each tap as a whole-number percentage of that total. Each percentage is finally turned into a small exponent and a mantissa, and the exponent depends on which band the percentage falls in.

A run begins with a one-cycle start pulse. All arithmetic is done one tap at a time. A single restoring divider handles both divisions, the percentage and the mantissa scaling. When the seventh coefficient is in place, a one-cycle done pulse is raised. The results are held until the next accepted start. If the chosen kernel sums to zero, the block does not divide. It raises an error flag and clears every coefficient.

Top module: `sharp_coef_norm`

## Requirements
- R1: Window code 0 selects the first kernel parameter, code 1 the second, and codes 2 and 3 the third. The code is captured when start is accepted.
- R2: The percentage of tap k is floor(tap_k * 100 / S), where S is the 16-bit unsigned total of the seven taps. Coefficient k sits at bits [3k+2:3k] of coef_exp_o and bits [9k+8:9k] of coef_mant_o.
- R3: A percentage below 25 gives exponent 3 and mantissa floor(p * 2048 / 100).
- R4: A percentage from 25 to 49 gives exponent 2 and mantissa floor(p * 1024 / 100). A percentage from 50 to 99 gives exponent 1 and mantissa floor(p * 512 / 100).
- R5: A percentage of 100 or more gives exponent 0 and mantissa floor(p * 256 / 100).
- R6: Every bit of coef_sign_o is always 0.
- R7: done_o is high for exactly one cycle per accepted start, and only after the block has been busy with that run.
- R8: When S is zero, err_o is 1 and every exponent and mantissa is 0 at done. A later run with a nonzero total clears err_o.
- R9: Coefficients and err_o do not change while the block is idle. A start pulse that arrives during a run is ignored, and the results of that run still follow the code captured at its start.
- R10: After reset, done_o and err_o are 0 and all coefficient fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a run |
| win_i | input | 2 | Window-size code that selects the kernel |
| done_o | output | 1 | One-cycle pulse when all coefficients are valid |
| err_o | output | 1 | The selected kernel summed to zero |
| coef_sign_o | output | 7 | Sign bit of each coefficient, always zero |
| coef_exp_o | output | 21 | Exponent of each coefficient, 3 bits per tap |
| coef_mant_o | output | 63 | Mantissa of each coefficient, 9 bits per tap |

## Verification
On every cycle, the bound checker checks that done is a single pulse that comes out of a busy phase. It also checks that results hold while the block is idle, that an error leaves every field cleared, and that each exponent at done goes with a mantissa inside the range its band allows. Only the bench scenarios can show that the exact mantissa and exponent values match the floor arithmetic for each kernel. The same goes for the mapping of codes 2 and 3 to the third kernel, for a start issued mid-run leaving the results untouched, and for a zero-sum kernel followed by a valid one clearing the error flag.

// File: rtl/sharp_coef_pkg.sv
package sharp_coef_pkg;

    // Percent scale used by both the normalization and the mantissa step.
    localparam int unsigned PCT_FULL        = 100;
    // Mantissa shift for the widest band (exponent 0); each step up adds one.
    localparam int unsigned MANT_SHIFT_BASE = 8;
    localparam int unsigned TABLE_COUNT     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM,
        ST_ZERO,
        ST_NORM_GO,
        ST_NORM_WAIT,
        ST_MANT_GO,
        ST_MANT_WAIT
    } norm_state_e;

    // Band of a percentage: small values get a larger exponent.
    function automatic logic [1:0] pct_band(input logic [7:0] pct);
        if (pct < 8'd25)       return 2'd3;
        else if (pct < 8'd50)  return 2'd2;
        else if (pct < 8'd100) return 2'd1;
        else                   return 2'd0;
    endfunction

endpackage

// File: rtl/sharp_tap_rom.sv
module sharp_tap_rom
    import sharp_coef_pkg::*;
#(
    parameter int unsigned NTAPS = 7,
    parameter int unsigned TAP_W = 12,
    parameter int unsigned WIN_W = 2,
    parameter int unsigned IDX_W = 3,
    parameter logic [NTAPS*TAP_W-1:0] TABLE_A = '0,
    parameter logic [NTAPS*TAP_W-1:0] TABLE_B = '0,
    parameter logic [NTAPS*TAP_W-1:0] TABLE_C = '0
) (
    input  logic [WIN_W-1:0] win_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [TAP_W-1:0] tap_o
);

    localparam int unsigned BANK_BITS = NTAPS * TAP_W;
    localparam logic [TABLE_COUNT*BANK_BITS-1:0] ALL_TABLES = {TABLE_C, TABLE_B, TABLE_A};

    logic [TAP_W-1:0] bank [TABLE_COUNT][NTAPS];
    logic [1:0]       sel;

    for (genvar g = 0; g < TABLE_COUNT; g++) begin : g_table
        for (genvar k = 0; k < NTAPS; k++) begin : g_tap
            assign bank[g][k] = ALL_TABLES[(g*NTAPS + k)*TAP_W +: TAP_W];
        end
    end

    always_comb begin
        if (win_i == '0)                sel = 2'd0;
        else if (win_i == WIN_W'(1))    sel = 2'd1;
        else                            sel = 2'd2;

        tap_o = '0;
        if (idx_i < IDX_W'(NTAPS)) begin
            tap_o = bank[sel][idx_i];
        end
    end

endmodule

// File: rtl/sharp_range_map.sv
module sharp_range_map
    import sharp_coef_pkg::*;
#(
    parameter int unsigned PCT_W = 8,
    parameter int unsigned EXP_W = 3,
    parameter int unsigned DIV_W = 19
) (
    input  logic [PCT_W-1:0] pct_i,
    output logic [EXP_W-1:0] exp_o,
    output logic [DIV_W-1:0] dividend_o
);

    logic [1:0] band;
    logic [3:0] shamt;

    always_comb begin
        band       = pct_band(8'(pct_i));
        shamt      = 4'(MANT_SHIFT_BASE) + 4'(band);
        exp_o      = EXP_W'(band);
        dividend_o = DIV_W'(pct_i) << shamt;
    end

endmodule

// File: rtl/sharp_seq_div.sv
module sharp_seq_div #(
    parameter int unsigned NUM_W = 19,
    parameter int unsigned DEN_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic             fin_o
);

    localparam int unsigned CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             run;
        logic             fin;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] den;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] den_ext;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        trial   = {s_q.rem, s_q.quo[NUM_W-1]};
        den_ext = {1'b0, s_q.den};

        if (!s_q.run) begin
            if (go_i) begin
                s_d.run = 1'b1;
                s_d.cnt = CNT_W'(NUM_W);
                s_d.den = den_i;
                s_d.rem = '0;
                s_d.quo = num_i;
            end
        end else begin
            if (trial >= den_ext) begin
                s_d.rem = DEN_W'(trial - den_ext);
                s_d.quo = {s_q.quo[NUM_W-2:0], 1'b1};
            end else begin
                s_d.rem = trial[DEN_W-1:0];
                s_d.quo = {s_q.quo[NUM_W-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt - CNT_W'(1);
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.run = 1'b0;
                s_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign quo_o = s_q.quo;
    assign fin_o = s_q.fin;

endmodule

// File: rtl/sharp_coef_norm.sv
module sharp_coef_norm
    import sharp_coef_pkg::*;
#(
    parameter int unsigned NTAPS  = 7,
    parameter int unsigned TAP_W  = 12,
    parameter int unsigned SUM_W  = 16,
    parameter int unsigned WIN_W  = 2,
    parameter int unsigned EXP_W  = 3,
    parameter int unsigned MANT_W = 9,
    parameter logic [NTAPS*TAP_W-1:0] TABLE_A =
        {12'd4, 12'd16, 12'd40, 12'd64, 12'd40, 12'd16, 12'd4},
    parameter logic [NTAPS*TAP_W-1:0] TABLE_B =
        {12'd2, 12'd10, 12'd30, 12'd50, 12'd30, 12'd10, 12'd2},
    parameter logic [NTAPS*TAP_W-1:0] TABLE_C =
        {12'd1, 12'd6, 12'd20, 12'd32, 12'd20, 12'd6, 12'd1}
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [WIN_W-1:0]        win_i,
    output logic                    done_o,
    output logic                    err_o,
    output logic [NTAPS-1:0]        coef_sign_o,
    output logic [NTAPS*EXP_W-1:0]  coef_exp_o,
    output logic [NTAPS*MANT_W-1:0] coef_mant_o
);

    localparam int unsigned IDX_W = (NTAPS > 1) ? $clog2(NTAPS) : 1;
    localparam int unsigned PCT_W = 8;
    localparam int unsigned MUL_W = TAP_W + 7;
    localparam int unsigned MAP_W = PCT_W + MANT_SHIFT_BASE + 3;
    localparam int unsigned DIV_W = (MUL_W > MAP_W) ? MUL_W : MAP_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NTAPS - 1);

    typedef struct packed {
        norm_state_e                   st;
        logic [WIN_W-1:0]              win;
        logic [IDX_W-1:0]              idx;
        logic [SUM_W-1:0]              sum;
        logic [PCT_W-1:0]              pct;
        logic                          err;
        logic                          done;
        logic [NTAPS-1:0][EXP_W-1:0]   exps;
        logic [NTAPS-1:0][MANT_W-1:0]  mants;
    } norm_state_t;

    norm_state_t s_d, s_q;

    logic [TAP_W-1:0] tap;
    logic [SUM_W-1:0] sum_nx;
    logic             div_go;
    logic [DIV_W-1:0] div_num;
    logic [SUM_W-1:0] div_den;
    logic [DIV_W-1:0] div_quo;
    logic             div_fin;
    logic [EXP_W-1:0] map_exp;
    logic [DIV_W-1:0] map_num;
    logic             busy;

    sharp_tap_rom #(
        .NTAPS   (NTAPS),
        .TAP_W   (TAP_W),
        .WIN_W   (WIN_W),
        .IDX_W   (IDX_W),
        .TABLE_A (TABLE_A),
        .TABLE_B (TABLE_B),
        .TABLE_C (TABLE_C)
    ) u_rom (
        .win_i (s_q.win),
        .idx_i (s_q.idx),
        .tap_o (tap)
    );

    sharp_range_map #(
        .PCT_W (PCT_W),
        .EXP_W (EXP_W),
        .DIV_W (DIV_W)
    ) u_map (
        .pct_i      (s_q.pct),
        .exp_o      (map_exp),
        .dividend_o (map_num)
    );

    sharp_seq_div #(
        .NUM_W (DIV_W),
        .DEN_W (SUM_W)
    ) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (div_go),
        .num_i  (div_num),
        .den_i  (div_den),
        .quo_o  (div_quo),
        .fin_o  (div_fin)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        div_go   = 1'b0;
        div_num  = '0;
        div_den  = '0;
        sum_nx   = s_q.sum + SUM_W'(tap);

        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.win = win_i;
                    s_d.sum = '0;
                    s_d.idx = '0;
                    s_d.st  = ST_SUM;
                end
            end
            ST_SUM: begin
                s_d.sum = sum_nx;
                if (s_q.idx == LAST_IDX) begin
                    s_d.idx = '0;
                    s_d.st  = (sum_nx == '0) ? ST_ZERO : ST_NORM_GO;
                end else begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                end
            end
            ST_ZERO: begin
                s_d.exps  = '0;
                s_d.mants = '0;
                s_d.err   = 1'b1;
                s_d.done  = 1'b1;
                s_d.st    = ST_IDLE;
            end
            ST_NORM_GO: begin
                s_d.err = 1'b0;
                div_go  = 1'b1;
                div_num = DIV_W'(tap) * DIV_W'(PCT_FULL);
                div_den = s_q.sum;
                s_d.st  = ST_NORM_WAIT;
            end
            ST_NORM_WAIT: begin
                if (div_fin) begin
                    s_d.pct = PCT_W'(div_quo);
                    s_d.st  = ST_MANT_GO;
                end
            end
            ST_MANT_GO: begin
                div_go              = 1'b1;
                div_num             = map_num;
                div_den             = SUM_W'(PCT_FULL);
                s_d.exps[s_q.idx]   = map_exp;
                s_d.st              = ST_MANT_WAIT;
            end
            ST_MANT_WAIT: begin
                if (div_fin) begin
                    s_d.mants[s_q.idx] = MANT_W'(div_quo);
                    if (s_q.idx == LAST_IDX) begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                        s_d.st  = ST_NORM_GO;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: ST_IDLE, default: '0};
        else         s_q <= s_d;
    end

    assign busy        = (s_q.st != ST_IDLE);
    assign done_o      = s_q.done;
    assign err_o       = s_q.err;
    assign coef_sign_o = '0;
    assign coef_exp_o  = s_q.exps;
    assign coef_mant_o = s_q.mants;

endmodule

// File: rtl/sharp_coef_norm_chk.sv
module sharp_coef_norm_chk #(
    parameter int unsigned NTAPS  = 7,
    parameter int unsigned EXP_W  = 3,
    parameter int unsigned MANT_W = 9
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    start_i,
    input logic                    busy_i,
    input logic                    done_i,
    input logic                    err_i,
    input logic [NTAPS*EXP_W-1:0]  coef_exp_i,
    input logic [NTAPS*MANT_W-1:0] coef_mant_i
);

    // R7: one-cycle done pulse
    a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    // R7: done only closes a busy phase
    a_r7_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> $past(busy_i));

    // R9: idle without start keeps results
    a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && !start_i) |=> ($stable(coef_exp_i) && $stable(coef_mant_i) && $stable(err_i)));

    // R8: error leaves all fields cleared
    a_r8_err_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |-> (coef_exp_i == '0 && coef_mant_i == '0));

    for (genvar k = 0; k < NTAPS; k++) begin : g_band
        logic [EXP_W-1:0]  e;
        logic [MANT_W-1:0] m;
        assign e = coef_exp_i[k*EXP_W +: EXP_W];
        assign m = coef_mant_i[k*MANT_W +: MANT_W];

        // R3: small band mantissa bound
        a_r3_band_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_i && !err_i && e == EXP_W'(3)) |-> (m <= MANT_W'(491)));

        // R4: middle bands mantissa window
        a_r4_band_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_i && !err_i && (e == EXP_W'(2) || e == EXP_W'(1))) |->
            (m >= MANT_W'(256) && m <= MANT_W'(506)));

        // R5: full band mantissa
        a_r5_band_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_i && !err_i && e == '0) |-> (m == MANT_W'(256)));
    end

endmodule

bind sharp_coef_norm sharp_coef_norm_chk #(
    .NTAPS  (NTAPS),
    .EXP_W  (EXP_W),
    .MANT_W (MANT_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_i      (busy),
    .done_i      (done_o),
    .err_i       (err_o),
    .coef_exp_i  (coef_exp_o),
    .coef_mant_i (coef_mant_o)
);

// File: tb/sim_sharp_coef_norm.sv
`timescale 1ns/1ps
module sim_sharp_coef_norm;

    localparam int NT = 7;
    localparam int TW = 12;
    localparam int EW = 3;
    localparam int MW = 9;

    // Kernel 0 spans three bands, kernel 1 has one tap at 100 %, kernel 2 sums to zero.
    localparam int K0 [NT] = '{5, 100, 2600, 1500, 600, 180, 15};
    localparam int K1 [NT] = '{0, 0, 0, 777, 0, 0, 0};
    localparam int K2 [NT] = '{0, 0, 0, 0, 0, 0, 0};
    localparam logic [NT*TW-1:0] P0 = {12'd15, 12'd180, 12'd600, 12'd1500, 12'd2600, 12'd100, 12'd5};
    localparam logic [NT*TW-1:0] P1 = {12'd0, 12'd0, 12'd0, 12'd777, 12'd0, 12'd0, 12'd0};
    localparam logic [NT*TW-1:0] P2 = '0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] win = '0;
    logic done, err;
    logic [NT-1:0] sgn;
    logic [NT*EW-1:0] expo;
    logic [NT*MW-1:0] mant;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sharp_coef_norm #(
        .NTAPS(NT), .TAP_W(TW), .EXP_W(EW), .MANT_W(MW),
        .TABLE_A(P0), .TABLE_B(P1), .TABLE_C(P2)
    ) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .win_i(win),
        .done_o(done), .err_o(err), .coef_sign_o(sgn),
        .coef_exp_o(expo), .coef_mant_o(mant)
    );

    function automatic int tap_of(int code, int k);
        if (code == 0) return K0[k];
        if (code == 1) return K1[k];
        return K2[k];
    endfunction

    task automatic model(input int code, input int k, output int e, output int m, output bit z);
        int s = 0;
        int v;
        for (int j = 0; j < NT; j++) s += tap_of(code, j);
        s = s & 16'hFFFF;
        z = (s == 0);
        if (z) begin e = 0; m = 0; return; end
        v = tap_of(code, k) * 100 / s;
        if (v < 25)       begin e = 3; m = v * 2048 / 100; end
        else if (v < 50)  begin e = 2; m = v * 1024 / 100; end
        else if (v < 100) begin e = 1; m = v * 512 / 100; end
        else              begin e = 0; m = v * 256 / 100; end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic pulse_start(input int code);
        @(negedge clk);
        start = 1'b1;
        win = 2'(code);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            if (done) begin seen = 1'b1; return; end
            @(negedge clk);
        end
    endtask

    task automatic check_result(input int code);
        int e, m, ae, am;
        bit z;
        for (int k = 0; k < NT; k++) begin
            model(code, k, e, m, z);
            ae = int'(expo[k*EW +: EW]);
            am = int'(mant[k*MW +: MW]);
            check(ae == e, "R1 R2 exponent", ae, e);
            if (z)           check(am == m, "R8 mantissa", am, m);
            else if (e == 3) check(am == m, "R3 mantissa", am, m);
            else if (e == 0) check(am == m, "R5 mantissa", am, m);
            else             check(am == m, "R4 mantissa", am, m);
            if (k == 0) check(err == z, "R8 error flag", int'(err), int'(z));
        end
        check(sgn == '0, "R6 sign", int'(sgn), 0);
    endtask

    task automatic run_case(input int code, input int inject, input int other);
        bit seen;
        logic [NT*EW-1:0] ex_s;
        logic [NT*MW-1:0] mn_s;
        logic er_s;
        pulse_start(code);
        if (inject > 0) begin
            repeat (inject) @(negedge clk);
            start = 1'b1;
            win = 2'(other);
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(seen);
        check(seen, "R7 done seen", int'(seen), 1);
        check_result(code);
        @(negedge clk);
        check(!done, "R7 done single cycle", int'(done), 0);
        ex_s = expo; mn_s = mant; er_s = err;
        repeat (5 + ($urandom % 20)) @(negedge clk);
        check(expo == ex_s && mant == mn_s && err == er_s, "R9 hold while idle", int'(err), int'(er_s));
        check(!done, "R7 no stray done", int'(done), 0);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL R7 watchdog: actual 0 expected 1");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!done, "R10 done", int'(done), 0);
        check(!err, "R10 err", int'(err), 0);
        check(expo == '0 && mant == '0, "R10 fields", int'(mant[MW-1:0]), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(0, 0, 0);      // R3 R4 bands
        run_case(1, 0, 0);      // R5 full band
        run_case(2, 0, 0);      // R8 zero sum
        run_case(0, 0, 0);      // R8 error clears
        run_case(3, 0, 0);      // R1 code 3 uses third kernel
        run_case(1, 40, 0);     // R9 start mid-run ignored
        run_case(0, 150, 1);    // R9 start mid-run ignored

        for (int i = 0; i < 16; i++) begin
            int code = int'($urandom % 4);
            int inj = 0;
            if (code < 2 && ($urandom % 2) == 1) inj = 1 + int'($urandom % 200);
            run_case(code, inj, int'($urandom % 4));
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule